// File: doc/BRIEF.md
# Block Transfer Sequencer

This block runs a multi-register load or store on behalf of a core's execute stage. A start pulse supplies a base address, a 16-bit selection mask over the general-purpose registers, and three flags. The flags choose load or store, pre- or post-increment addressing, and whether the updated base is written back. The sequencer then issues one word-sized memory request for each selected register. It walks the mask from the lowest index to the highest and assigns consecutive word addresses.

Each request goes out on a valid/ready channel. The request holds the word address, the register index and a write flag. Back-pressure rules are as follows. Once `req_valid` is raised, it stays high and the request fields stay unchanged until a cycle in which `req_ready` is also high. A request is counted as transferred only in such a cycle, and the next request comes out in the following cycle. After the last transfer the block raises a one-cycle `done`. When writeback was requested, it also presents the updated base on `wb_value` in that same cycle. The register file and the memory data path belong to the surrounding logic.

Top module: `blk_xfer_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high up to and including the `done` cycle.
- R2: Exactly one request is issued per set bit of the mask. Requests come in ascending register index, and `req_reg` carries the index in binary (bit i of the mask is register i).
- R3: Successive requests use word addresses 4 bytes apart. In post-increment mode (`start_pre`=0) the first address equals the base. Example: base 1000 with mask bits {0,1,6,7} gives addresses 1000, 1004, 1008 and 1012 for registers 0, 1, 6 and 7.
- R4: In pre-increment mode (`start_pre`=1) the first address is base+4.
- R5: While `req_valid` is high and `req_ready` is low, the request stays valid and its address, index and write flag do not change. The sequence advances only on a cycle with both high.
- R6: `done` is high for exactly one cycle, the cycle after the final transfer.
- R7: In the `done` cycle, `wb_valid` equals the latched writeback flag. When it is set, `wb_value` = base + 4 × (number of set mask bits), in both addressing modes.
- R8: An all-zero mask issues no request and raises `done` in the cycle after the start is accepted.
- R9: A start pulse while `busy` is high has no effect on the running sequence (addresses, indices, write flag, writeback).
- R10: `req_write` equals the `start_store` flag latched at acceptance for every request of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_base | input | 32 | Base address |
| start_list | input | 16 | Register selection mask |
| start_pre | input | 1 | 1 = pre-increment, 0 = post-increment |
| start_wb | input | 1 | Request base writeback |
| start_store | input | 1 | 1 = store, 0 = load |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 32 | Word address of request |
| req_reg | output | 4 | Register index of request |
| req_write | output | 1 | Request is a store |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Writeback value present (with done) |
| wb_value | output | 32 | Updated base address |

## Verification
The bench builds the block with its default parameters: 16 registers and 32-bit addresses. This makes the full mask, the single top register 15 and the empty mask all reachable alongside random masks. Random bases near the top of the 32-bit range exercise address wraparound in both the request addresses and the writeback sum. A random ready pattern produces stalls on first, middle and last requests. Start pulses injected during running sequences, including in the `done` cycle, test that they are ignored.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pending,
  output logic [NREG-1:0]  lowest,
  output logic [IDX_W-1:0] idx
);
  // isolate lowest set bit
  assign lowest = pending & (~pending + NREG'(1));

  // encode its position, one OR tree per index bit
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    logic [NREG-1:0] sel;
    for (genvar i = 0; i < NREG; i++) begin : g_sel
      assign sel[i] = (((i >> b) % 2) == 1);
    end
    assign idx[b] = |(lowest & sel);
  end
endmodule

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr
  import blk_xfer_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [NREG-1:0]   list,
  input  logic              pre,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wb_value
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0] nsel;

  always_comb begin
    nsel = '0;
    for (int i = 0; i < NREG; i++) nsel = nsel + CNT_W'(list[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      wb_value <= '0;
    end else if (load) begin
      addr     <= pre ? base + STEP : base;
      wb_value <= base + (ADDR_W'(nsel) * STEP);
    end else if (step) begin
      addr     <= addr + STEP;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> addr == $past(addr) + STEP) else $error("addr step"); // R3
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import blk_xfer_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] list,
  input  logic            store_in,
  input  logic            wb_in,
  input  logic            req_ready,
  input  logic [NREG-1:0] lowest,
  output logic [NREG-1:0] pending,
  output logic            accept,
  output logic            fire,
  output logic            busy,
  output logic            req_valid,
  output logic            req_write,
  output logic            done,
  output logic            wb_valid
);
  seq_state_e      state;
  logic            wb_flag;
  logic [NREG-1:0] rest;

  assign accept    = start && (state == ST_IDLE);
  assign req_valid = (state == ST_RUN);
  assign fire      = req_valid && req_ready;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign wb_valid  = done && wb_flag;
  assign rest      = pending & ~lowest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pending   <= '0;
      req_write <= 1'b0;
      wb_flag   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          pending   <= list;
          req_write <= store_in;
          wb_flag   <= wb_in;
          state     <= (list == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (req_ready) begin
          pending <= rest;
          if (rest == '0) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done pulse"); // R6
  AST_ONE_PER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones(pending) == $countones($past(pending)) - 1) else $error("pop"); // R2
  AST_BUSY_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_write) && $stable(wb_flag)) else $error("flags"); // R9
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && list == '0) |=> done && !req_valid) else $error("empty"); // R8
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [NREG-1:0]   start_list,
  input  logic              start_pre,
  input  logic              start_wb,
  input  logic              start_store,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  req_reg,
  output logic              req_write,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);
  logic [NREG-1:0] pending;
  logic [NREG-1:0] lowest;
  logic            accept;
  logic            fire;

  blk_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .pending (pending),
    .lowest  (lowest),
    .idx     (req_reg)
  );

  blk_xfer_ctrl #(.NREG(NREG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .list      (start_list),
    .store_in  (start_store),
    .wb_in     (start_wb),
    .req_ready (req_ready),
    .lowest    (lowest),
    .pending   (pending),
    .accept    (accept),
    .fire      (fire),
    .busy      (busy),
    .req_valid (req_valid),
    .req_write (req_write),
    .done      (done),
    .wb_valid  (wb_valid)
  );

  blk_xfer_addr #(.NREG(NREG), .ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (fire),
    .base     (start_base),
    .list     (start_list),
    .pre      (start_pre),
    .addr     (req_addr),
    .wb_value (wb_value)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_reg)
      && $stable(req_write)) else $error("hold"); // R5
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid || (req_reg > $past(req_reg))) else $error("order"); // R2
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done) else $error("wb"); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && busy) else $error("done state"); // R1
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_base = '0;
  logic [15:0] start_list = '0;
  logic        start_pre = 1'b0, start_wb = 1'b0, start_store = 1'b0;
  logic        req_ready = 1'b0;
  logic        busy, req_valid, req_write, done, wb_valid;
  logic [31:0] req_addr, wb_value;
  logic [3:0]  req_reg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  blk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_list(start_list), .start_pre(start_pre), .start_wb(start_wb),
    .start_store(start_store), .busy(busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_reg(req_reg),
    .req_write(req_write), .done(done), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  // behavioural reference: 0 idle, 1 running, 2 finishing
  int          m_state = 0;
  int          q_reg[$];
  logic [31:0] q_addr[$];
  logic [31:0] m_wbv = '0;
  bit          m_wb = 0, m_store = 0, m_pre = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; q_reg.delete(); q_addr.delete();
    end else begin
      case (m_state)
        0: if (start) begin
          logic [31:0] a;
          int n;
          a = start_base + (start_pre ? 32'd4 : 32'd0);
          n = 0;
          for (int i = 0; i < 16; i++) if (start_list[i]) begin
            q_reg.push_back(i); q_addr.push_back(a); a += 4; n++;
          end
          m_wbv = start_base + 32'(4 * n);
          m_wb = start_wb; m_store = start_store; m_pre = start_pre;
          m_state = (n == 0) ? 2 : 1;
        end
        1: if (req_ready) begin
          void'(q_reg.pop_front()); void'(q_addr.pop_front());
          if (q_reg.size() == 0) m_state = 2;
        end
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished && cycles > 0) begin
      chk("R1", "busy", 32'(busy), 32'(m_state != 0));
      chk("R5", "req_valid", 32'(req_valid), 32'(m_state == 1));
      chk("R6 R8", "done", 32'(done), 32'(m_state == 2));
      chk("R7", "wb_valid", 32'(wb_valid), 32'(m_state == 2 && m_wb));
      if (m_state == 2 && m_wb) chk("R7", "wb_value", wb_value, m_wbv);
      if (m_state == 1) begin
        chk("R2", "req_reg", 32'(req_reg), 32'(q_reg[0]));
        chk(m_pre ? "R4" : "R3", "req_addr", req_addr, q_addr[0]);
        chk("R10", "req_write", 32'(req_write), 32'(m_store));
      end
    end
  end

  // memory back-pressure
  bit ready_free = 0;
  initial forever begin
    @(negedge clk);
    req_ready = ready_free ? 1'b1 : (($urandom % 4) != 0);
  end

  // one sequence; stray starts while busy exercise R9
  task automatic run_seq(logic [31:0] b, logic [15:0] l, bit p, bit w, bit s, bit noise);
    @(negedge clk);
    start = 1; start_base = b; start_list = l; start_pre = p; start_wb = w; start_store = s;
    @(negedge clk);
    start = 0;
    while (m_state != 0) begin
      @(negedge clk);
      if (noise && ($urandom % 5 == 0)) begin
        start = 1; start_base = $urandom; start_list = 16'($urandom);
        start_pre = $urandom; start_wb = $urandom; start_store = $urandom;
      end else start = 0;
    end
    start = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3: base 1000, mask {0,1,6,7}, post-increment load
    run_seq(32'd1000, 16'h00C3, 0, 0, 0, 0);
    // R4 R7: same mask pre-increment store with writeback
    run_seq(32'd1000, 16'h00C3, 1, 1, 1, 1);
    // R8: empty mask with and without writeback
    run_seq(32'h40, 16'h0000, 0, 1, 0, 0);
    run_seq(32'h40, 16'h0000, 1, 0, 1, 1);
    // full mask, top register only, wraparound
    run_seq(32'hFFFF_FFF0, 16'hFFFF, 1, 1, 0, 1);
    run_seq(32'h2000, 16'h8000, 0, 1, 1, 1);
    ready_free = 1;
    run_seq(32'h100, 16'h0001, 1, 1, 0, 0);
    run_seq(32'h200, 16'hA5A5, 0, 1, 1, 0);
    ready_free = 0;
    for (int k = 0; k < 40; k++)
      run_seq($urandom, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule